// File: doc/BRIEF.md
# Status-Driven Burst Credit Scheduler

This block sits on the transmit side of a packet interface that gets flow control through a status calendar. The far end reports one 2-bit status word per calendar slot. A calendar maps each slot to a logical port (LP), and each status word sets that LP's burst credit. The credit is counted in 16-byte blocks and sized by one of two programmable limits, one for a starving port and one for a hungry port. On every cycle the scheduler chooses one LP to receive a burst. To be chosen, an LP must hold credit for a full burst and must also have a full burst of data waiting. Starving ports always go before hungry ones. Within each class the choice rotates, starting after the last LP that was granted.

The calendar has two banks. Writes always go to the shadow bank. A swap request only takes effect when a full calendar cycle ends, which is the programmed length run through the programmed number of repeats. A running status sequence is therefore never re-mapped partway through. An optional multiple-burst mode takes the burst size off the credit instead of clearing it, so one status update can cover several bursts when updates are slow to arrive.

Top module: `burst_credit_sched`

## Requirements
- R1: After reset there is no grant, every LP has zero credit, the active calendar bank is 0, the calendar points at slot 0, and active entry k maps to LP k mod NUM_LP.
- R2: A status word is applied to the LP that the active calendar entry of the current slot names. Code 2'b00 (starving) loads the starving limit as credit, code 2'b01 (hungry) loads the hungry limit, and code 2'b10 (satisfied) loads zero.
- R3: Status code 2'b11 has no effect: that LP's credit and class stay unchanged.
- R4: An LP is eligible only when its credit is at least the burst unit and its data count is at least the burst unit. The unit is non-zero and is counted in blocks.
- R5: If any starving LP is eligible, the grant goes to a starving LP and never to a hungry one.
- R6: Within a class, the grant goes to the first eligible LP found searching upward (with wrap) from the LP after the last one granted. After reset, the search starts at LP 0.
- R7: With multiple-burst mode off, a grant sets that LP's credit to zero, so there is one burst per status update.
- R8: With multiple-burst mode on, a grant subtracts one burst unit from the credit. The LP stays eligible while its credit is still at least one unit.
- R9: Each status word moves the calendar to the next slot. After slot cfg_cal_len_m1 it wraps to slot 0. A full calendar cycle is (cfg_cal_len_m1+1) x (cfg_cal_rep_m1+1) status words.
- R10: Calendar writes go to the inactive bank. A swap request flips the active bank only on the status word that ends a full calendar cycle. The request is held until then.
- R11: A grant appears on gnt_valid/gnt_lp one clock after the cycle in which the LP was eligible. gnt_len carries the burst unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | One status word present this cycle |
| st_code | input | 2 | Status word: 00 starving, 01 hungry, 10 satisfied, 11 no change |
| cfg_lim_starve | input | CRW | Starving credit limit in 16-byte blocks |
| cfg_lim_hungry | input | CRW | Hungry credit limit in 16-byte blocks |
| cfg_unit | input | CRW | Burst unit in blocks |
| cfg_multi | input | 1 | Multiple-burst mode enable |
| cfg_cal_len_m1 | input | CAW | Calendar length minus one |
| cfg_cal_rep_m1 | input | REPW | Calendar repeat count minus one |
| cal_wr_en | input | 1 | Write one shadow calendar entry |
| cal_wr_addr | input | CAW | Shadow entry index |
| cal_wr_lp | input | LPW | LP written into the entry |
| cal_swap_req | input | 1 | Request a bank swap at the next cycle end |
| lp_dav | input | NUM_LP*DVW | Per-LP buffered data in blocks, LP0 in the low bits |
| gnt_valid | output | 1 | Burst grant issued |
| gnt_lp | output | LPW | Granted LP |
| gnt_len | output | CRW | Granted burst length in blocks |
| cal_bank | output | 1 | Active calendar bank |

## Verification
A stale or corrupt credit shows up at the ports as a grant that should not be there, or one that is missing. It appears in the first cycle after the next data count that would make the LP eligible. A wrong class or rotation pointer shows up within one or two grants as a change in grant order. A slot counter that is off by one, or a swap that fires early, sends a status word to the wrong LP. That becomes visible at the first grant after the affected update, and through cal_bank on the status word that should have ended the cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    STAT_STARVE = 2'b00,
    STAT_HUNGRY = 2'b01,
    STAT_SATED  = 2'b10,
    STAT_KEEP   = 2'b11
  } lp_stat_e;
endpackage

// File: rtl/bcs_cal_seq.sv
module bcs_cal_seq #(
  parameter int NUM_LP    = 8,
  parameter int CAL_DEPTH = 16,
  parameter int REPW      = 8,
  localparam int LPW      = $clog2(NUM_LP),
  localparam int CAW      = $clog2(CAL_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [CAW-1:0]  len_m1,
  input  logic [REPW-1:0] rep_m1,
  input  logic            wr_en,
  input  logic [CAW-1:0]  wr_addr,
  input  logic [LPW-1:0]  wr_lp,
  input  logic            swap_req,
  output logic [LPW-1:0]  slot_lp,
  output logic            cyc_end,
  output logic            bank
);
  logic [LPW-1:0]  tbl [2][CAL_DEPTH];
  logic [CAW-1:0]  slot_q;
  logic [REPW-1:0] rep_q;
  logic            bank_q;
  logic            swap_pend_q;
  logic            pass_end;

  // end of one pass through the programmed length
  always_comb begin
    pass_end = st_valid && (slot_q >= len_m1);
    cyc_end  = pass_end && (rep_q >= rep_m1);
  end

  assign slot_lp = tbl[bank_q][slot_q];
  assign bank    = bank_q;

  // both banks come up as an identity map; writes land in the shadow bank
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int e = 0; e < CAL_DEPTH; e++)
          tbl[b][e] <= LPW'(e % NUM_LP);
    end else if (wr_en) begin
      tbl[~bank_q][wr_addr] <= wr_lp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q      <= '0;
      rep_q       <= '0;
      bank_q      <= 1'b0;
      swap_pend_q <= 1'b0;
    end else begin
      if (st_valid) begin
        if (pass_end) begin
          slot_q <= '0;
          rep_q  <= cyc_end ? '0 : rep_q + 1'b1;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
      if (cyc_end && (swap_pend_q || swap_req)) begin
        bank_q      <= ~bank_q;
        swap_pend_q <= 1'b0;
      end else if (swap_req) begin
        swap_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bcs_credit_bank.sv
module bcs_credit_bank
  import bcs_pkg::*;
#(
  parameter int NUM_LP = 8,
  parameter int CRW    = 5,
  parameter int DVW    = 8,
  localparam int LPW   = $clog2(NUM_LP)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         upd_valid,
  input  logic [LPW-1:0]               upd_lp,
  input  lp_stat_e                     upd_code,
  input  logic [CRW-1:0]               lim_starve,
  input  logic [CRW-1:0]               lim_hungry,
  input  logic [CRW-1:0]               unit,
  input  logic                         multi,
  input  logic [NUM_LP-1:0][DVW-1:0]   dav,
  input  logic                         take,
  input  logic [LPW-1:0]               take_lp,
  output logic [NUM_LP-1:0][CRW-1:0]   credit,
  output logic [NUM_LP-1:0]            ready_starve,
  output logic [NUM_LP-1:0]            ready_hungry
);
  function automatic logic [CRW-1:0] load_value(input lp_stat_e code,
      input logic [CRW-1:0] cur, input logic [CRW-1:0] s, input logic [CRW-1:0] h);
    case (code)
      STAT_STARVE: return s;
      STAT_HUNGRY: return h;
      STAT_SATED:  return '0;
      default:     return cur;
    endcase
  endfunction

  function automatic logic [CRW-1:0] spend(input logic [CRW-1:0] cur,
      input logic [CRW-1:0] u, input logic m);
    return m ? cur - u : '0;
  endfunction

  function automatic logic burst_ready(input logic [CRW-1:0] cred,
      input logic [DVW-1:0] d, input logic [CRW-1:0] u);
    return (u != '0) && (cred >= u) && (d >= DVW'(u));
  endfunction

  for (genvar i = 0; i < NUM_LP; i++) begin : g_lp
    lp_stat_e       lvl_q;
    logic [CRW-1:0] cred_q;
    logic           hit_upd;
    logic           hit_take;

    assign hit_upd  = upd_valid && (upd_lp == LPW'(i)) && (upd_code != STAT_KEEP);
    assign hit_take = take && (take_lp == LPW'(i));

    // a fresh status wins over a grant in the same cycle
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cred_q <= '0;
        lvl_q  <= STAT_SATED;
      end else if (hit_upd) begin
        cred_q <= load_value(upd_code, cred_q, lim_starve, lim_hungry);
        lvl_q  <= upd_code;
      end else if (hit_take) begin
        cred_q <= spend(cred_q, unit, multi);
      end
    end

    assign credit[i]       = cred_q;
    assign ready_starve[i] = (lvl_q == STAT_STARVE) && burst_ready(cred_q, dav[i], unit);
    assign ready_hungry[i] = (lvl_q == STAT_HUNGRY) && burst_ready(cred_q, dav[i], unit);
  end
endmodule

// File: rtl/bcs_rr_pick.sv
module bcs_rr_pick #(
  parameter int NUM_LP = 8,
  localparam int LPW   = $clog2(NUM_LP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LP-1:0] req_hi,
  input  logic [NUM_LP-1:0] req_lo,
  output logic              pick_v,
  output logic [LPW-1:0]    pick_lp
);
  logic [LPW-1:0]    last_q;
  logic [NUM_LP-1:0] sel_mask;

  function automatic logic [LPW:0] first_after(input logic [NUM_LP-1:0] mask,
      input logic [LPW-1:0] last);
    logic           hit;
    logic [LPW-1:0] sel;
    hit = 1'b0;
    sel = '0;
    for (int k = 1; k <= NUM_LP; k++) begin
      int idx;
      idx = (int'(last) + k) % NUM_LP;
      if (!hit && mask[idx]) begin
        hit = 1'b1;
        sel = LPW'(idx);
      end
    end
    return {hit, sel};
  endfunction

  always_comb begin
    sel_mask          = (|req_hi) ? req_hi : req_lo;
    {pick_v, pick_lp} = first_after(sel_mask, last_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= LPW'(NUM_LP - 1);
    else if (pick_v) last_q <= pick_lp;
  end
endmodule

// File: rtl/burst_credit_sched.sv
module burst_credit_sched
  import bcs_pkg::*;
#(
  parameter int NUM_LP    = 8,
  parameter int CAL_DEPTH = 16,
  parameter int CRW       = 5,
  parameter int DVW       = 8,
  parameter int REPW      = 8,
  localparam int LPW      = $clog2(NUM_LP),
  localparam int CAW      = $clog2(CAL_DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [1:0]            st_code,
  input  logic [CRW-1:0]        cfg_lim_starve,
  input  logic [CRW-1:0]        cfg_lim_hungry,
  input  logic [CRW-1:0]        cfg_unit,
  input  logic                  cfg_multi,
  input  logic [CAW-1:0]        cfg_cal_len_m1,
  input  logic [REPW-1:0]       cfg_cal_rep_m1,
  input  logic                  cal_wr_en,
  input  logic [CAW-1:0]        cal_wr_addr,
  input  logic [LPW-1:0]        cal_wr_lp,
  input  logic                  cal_swap_req,
  input  logic [NUM_LP*DVW-1:0] lp_dav,
  output logic                  gnt_valid,
  output logic [LPW-1:0]        gnt_lp,
  output logic [CRW-1:0]        gnt_len,
  output logic                  cal_bank
);
  logic [NUM_LP-1:0][DVW-1:0] dav_arr;
  logic [NUM_LP-1:0][CRW-1:0] credit;
  logic [NUM_LP-1:0]          rdy_s;
  logic [NUM_LP-1:0]          rdy_h;
  logic [LPW-1:0]             slot_lp;
  logic                       cyc_end;
  logic                       pick_v;
  logic [LPW-1:0]             pick_lp;

  assign dav_arr = lp_dav;

  bcs_cal_seq #(.NUM_LP(NUM_LP), .CAL_DEPTH(CAL_DEPTH), .REPW(REPW)) u_cal (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid),
    .len_m1(cfg_cal_len_m1), .rep_m1(cfg_cal_rep_m1),
    .wr_en(cal_wr_en), .wr_addr(cal_wr_addr), .wr_lp(cal_wr_lp),
    .swap_req(cal_swap_req), .slot_lp(slot_lp), .cyc_end(cyc_end), .bank(cal_bank)
  );

  bcs_credit_bank #(.NUM_LP(NUM_LP), .CRW(CRW), .DVW(DVW)) u_cred (
    .clk(clk), .rst_n(rst_n), .upd_valid(st_valid), .upd_lp(slot_lp),
    .upd_code(lp_stat_e'(st_code)), .lim_starve(cfg_lim_starve),
    .lim_hungry(cfg_lim_hungry), .unit(cfg_unit), .multi(cfg_multi),
    .dav(dav_arr), .take(pick_v), .take_lp(pick_lp), .credit(credit),
    .ready_starve(rdy_s), .ready_hungry(rdy_h)
  );

  bcs_rr_pick #(.NUM_LP(NUM_LP)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_hi(rdy_s), .req_lo(rdy_h),
    .pick_v(pick_v), .pick_lp(pick_lp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_lp    <= '0;
      gnt_len   <= '0;
    end else begin
      gnt_valid <= pick_v;
      gnt_lp    <= pick_lp;
      gnt_len   <= cfg_unit;
    end
  end
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int NUM_LP = 8,
  parameter int CRW    = 5,
  localparam int LPW   = $clog2(NUM_LP)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pick_v,
  input logic [LPW-1:0]             pick_lp,
  input logic [NUM_LP-1:0]          rdy_s,
  input logic [NUM_LP-1:0]          rdy_h,
  input logic                       gnt_valid,
  input logic [LPW-1:0]             gnt_lp,
  input logic                       cal_bank,
  input logic                       cyc_end,
  input logic                       upd_valid,
  input logic [LPW-1:0]             upd_lp,
  input logic [1:0]                 upd_code,
  input logic                       cfg_multi,
  input logic [CRW-1:0]             lim_s,
  input logic [NUM_LP-1:0][CRW-1:0] credit
);
  // R11
  grant_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_v |=> (gnt_valid && gnt_lp == $past(pick_lp)));

  // R11
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_v |=> !gnt_valid);

  // R4
  eligible_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_v |-> (rdy_s[pick_lp] || rdy_h[pick_lp]));

  // R5
  starve_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_v && (|rdy_s)) |-> rdy_s[pick_lp]);

  // R10
  swap_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cal_bank) |-> $past(cyc_end));

  // R2
  starve_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_code == 2'b00) |=> credit[$past(upd_lp)] == $past(lim_s));

  // R3
  keep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_code == 2'b11 && !(pick_v && pick_lp == upd_lp))
      |=> credit[$past(upd_lp)] == $past(credit[upd_lp]));

  // R7
  single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_v && !cfg_multi && !(upd_valid && upd_lp == pick_lp && upd_code != 2'b11))
      |=> credit[$past(pick_lp)] == '0);
endmodule

bind burst_credit_sched bcs_chk #(.NUM_LP(NUM_LP), .CRW(CRW)) u_bcs_chk (
  .clk(clk), .rst_n(rst_n), .pick_v(pick_v), .pick_lp(pick_lp),
  .rdy_s(rdy_s), .rdy_h(rdy_h), .gnt_valid(gnt_valid), .gnt_lp(gnt_lp),
  .cal_bank(cal_bank), .cyc_end(cyc_end), .upd_valid(st_valid),
  .upd_lp(slot_lp), .upd_code(st_code), .cfg_multi(cfg_multi),
  .lim_s(cfg_lim_starve), .credit(credit)
);

// File: tb/burst_credit_sched_bench.sv
module burst_credit_sched_bench;
  localparam int NLP = 8;
  localparam int CD  = 16;
  localparam int CRW = 5;
  localparam int DVW = 8;
  localparam int RPW = 8;

  // {multi, dav_ok[7:0], codes (LP0 in bits 1:0)}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'hFF, 16'h0000},
    {1'b0, 8'hFF, 16'h0055},
    {1'b0, 8'hFF, 16'hFFFF},
    {1'b0, 8'hD7, 16'h3124},
    {1'b0, 8'hFF, 16'hFFFF},
    {1'b1, 8'hFF, 16'h0000},
    {1'b1, 8'h0F, 16'h5555},
    {1'b1, 8'hFF, 16'hFFFF}
  };
  localparam string VREQ [8] = '{
    "R2 R6 R7 all starving", "R5 R6 starving before hungry", "R3 R7 keep code restores nothing",
    "R2 R4 mixed with short data", "R3 R4 retained credit", "R8 two bursts each",
    "R8 hungry single unit", "R8 R3 retained hungry credit"
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n;
  logic                 st_valid;
  logic [1:0]           st_code;
  logic [CRW-1:0]       cfg_lim_starve, cfg_lim_hungry, cfg_unit;
  logic                 cfg_multi;
  logic [3:0]           cfg_cal_len_m1;
  logic [RPW-1:0]       cfg_cal_rep_m1;
  logic                 cal_wr_en;
  logic [3:0]           cal_wr_addr;
  logic [2:0]           cal_wr_lp;
  logic                 cal_swap_req;
  logic [NLP*DVW-1:0]   lp_dav;
  logic                 gnt_valid;
  logic [2:0]           gnt_lp;
  logic [CRW-1:0]       gnt_len;
  logic                 cal_bank;

  burst_credit_sched #(.NUM_LP(NLP), .CAL_DEPTH(CD), .CRW(CRW), .DVW(DVW), .REPW(RPW))
    u_burst_credit_sched (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_code(st_code),
    .cfg_lim_starve(cfg_lim_starve), .cfg_lim_hungry(cfg_lim_hungry),
    .cfg_unit(cfg_unit), .cfg_multi(cfg_multi), .cfg_cal_len_m1(cfg_cal_len_m1),
    .cfg_cal_rep_m1(cfg_cal_rep_m1), .cal_wr_en(cal_wr_en), .cal_wr_addr(cal_wr_addr),
    .cal_wr_lp(cal_wr_lp), .cal_swap_req(cal_swap_req), .lp_dav(lp_dav),
    .gnt_valid(gnt_valid), .gnt_lp(gnt_lp), .gnt_len(gnt_len), .cal_bank(cal_bank)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int m_cred [NLP];
  int m_lvl  [NLP];
  int m_last;
  int e_lp [64];
  int e_n;
  int a_lp [64];
  int a_len [64];
  int a_n;
  int a_first;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected credit effect of one status word (R2, R3)
  task automatic model_status(input int lp, input logic [1:0] code);
    case (code)
      2'b00: begin m_cred[lp] = int'(cfg_lim_starve); m_lvl[lp] = 0; end
      2'b01: begin m_cred[lp] = int'(cfg_lim_hungry); m_lvl[lp] = 1; end
      2'b10: begin m_cred[lp] = 0; m_lvl[lp] = 2; end
      default: ;
    endcase
  endtask

  task automatic send_pass(input logic [15:0] codes, input bit reversed);
    for (int s = 0; s < NLP; s++) begin
      @(negedge clk);
      st_valid = 1'b1;
      st_code  = codes[2*s +: 2];
      model_status(reversed ? NLP-1-s : s, codes[2*s +: 2]);
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic set_dav(input logic [7:0] ok);
    for (int i = 0; i < NLP; i++)
      lp_dav[i*DVW +: DVW] = ok[i] ? DVW'(40) : DVW'(cfg_unit - 1'b1);
  endtask

  // grant order stated by R4 R5 R6 R7 R8, built as a queue of picks
  task automatic model_expect(input logic [7:0] ok);
    e_n = 0;
    repeat (64) begin
      int pick;
      pick = -1;
      for (int pr = 0; pr < 2; pr++) begin
        for (int k = 1; k <= NLP; k++) begin
          int i;
          i = (m_last + k) % NLP;
          if (pick < 0 && m_lvl[i] == pr && m_cred[i] >= int'(cfg_unit) && ok[i]) pick = i;
        end
        if (pick >= 0) break;
      end
      if (pick < 0) break;
      e_lp[e_n] = pick;
      e_n++;
      m_last = pick;
      m_cred[pick] = cfg_multi ? m_cred[pick] - int'(cfg_unit) : 0;
    end
  endtask

  task automatic run_window(input logic [7:0] ok);
    model_expect(ok);
    @(negedge clk);
    set_dav(ok);
    a_n = 0;
    a_first = -1;
    for (int c = 1; c <= 26; c++) begin
      @(negedge clk);
      if (gnt_valid) begin
        if (a_first < 0) a_first = c;
        if (a_n < 64) begin
          a_lp[a_n]  = int'(gnt_lp);
          a_len[a_n] = int'(gnt_len);
        end
        a_n++;
      end
      if (c == 24) set_dav(8'h00);
    end
  endtask

  task automatic compare(input string req);
    int bad_i;
    int bad_l;
    bad_i = -1;
    bad_l = -1;
    check(a_n == e_n, {req, " grant count"}, a_n, e_n);
    for (int i = 0; i < e_n && i < a_n; i++) begin
      if (bad_i < 0 && a_lp[i] != e_lp[i]) bad_i = i;
      if (bad_l < 0 && a_len[i] != int'(cfg_unit)) bad_l = i;
    end
    if (bad_i >= 0) check(1'b0, {req, " grant order"}, a_lp[bad_i], e_lp[bad_i]);
    else            check(1'b1, {req, " grant order"}, 0, 0);
    // R11 burst length
    if (bad_l >= 0) check(1'b0, "R11 gnt_len", a_len[bad_l], int'(cfg_unit));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_code = 2'b11;
    cfg_lim_starve = 5'd4; cfg_lim_hungry = 5'd2; cfg_unit = 5'd2; cfg_multi = 1'b0;
    cfg_cal_len_m1 = 4'd7; cfg_cal_rep_m1 = '0;
    cal_wr_en = 1'b0; cal_wr_addr = '0; cal_wr_lp = '0; cal_swap_req = 1'b0;
    lp_dav = '0;
    for (int i = 0; i < NLP; i++) begin m_cred[i] = 0; m_lvl[i] = 2; end
    m_last = NLP - 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(gnt_valid == 1'b0, "R1 gnt_valid after reset", int'(gnt_valid), 0);
    check(cal_bank == 1'b0, "R1 cal_bank after reset", int'(cal_bank), 0);
    run_window(8'hFF);
    compare("R1 zero credit gives no grant");

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      cfg_multi = VEC[v][24];
      send_pass(VEC[v][15:0], 1'b0);
      run_window(VEC[v][23:16]);
      compare(VREQ[v]);
    end

    // R9 R10: two-pass calendar cycle, swap to a reversed map
    @(negedge clk);
    cfg_multi = 1'b0;
    cfg_cal_rep_m1 = 8'd1;
    for (int e = 0; e < NLP; e++) begin
      @(negedge clk);
      cal_wr_en = 1'b1; cal_wr_addr = 4'(e); cal_wr_lp = 3'(NLP-1-e);
    end
    @(negedge clk);
    cal_wr_en = 1'b0;
    cal_swap_req = 1'b1;
    @(negedge clk);
    cal_swap_req = 1'b0;
    send_pass(16'hFFFC, 1'b0);
    check(cal_bank == 1'b0, "R10 bank held mid-cycle", int'(cal_bank), 0);
    send_pass(16'hFFFF, 1'b0);
    check(cal_bank == 1'b1, "R9 R10 bank flips at cycle end", int'(cal_bank), 1);
    send_pass(16'hFFFC, 1'b1);
    run_window(8'hFF);
    compare("R2 R9 R10 swapped map");
    check(a_first == 1, "R11 grant latency", a_first, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule